// File: doc/BRIEF.md
# Memory Barrier Sequencing Unit

This unit sits between a core's load/store issue path and a system bus command port. It forwards ordinary data accesses and instruction fetches to the bus unchanged. It also executes two kinds of memory barrier. A full barrier stops every later request and waits until every earlier data access has finished its data phase. If barrier broadcast is enabled, it then issues a SYNC command and waits for a response that carries no address retry. A flowing barrier does not wait. It places an ORDER command into the outgoing stream at its own position between the surrounding accesses.

An internal counter tracks outstanding data accesses. It rises by one for each data command the bus accepts and falls by one for each data-phase completion pulse. Instruction fetches never enter this count. Only one full barrier can be in progress at a time. Any request that arrives during that time, including another barrier, waits with `req_ready` held low.

Top module: `barrier_seq`

## Requirements
- R1: In the idle state, a data request (`req_op`=2'b00) or a fetch request (`req_op`=2'b01) appears on `bus_valid`/`bus_tt`/`bus_addr` with its command code and address unchanged. The request handshake (`req_ready`) follows `bus_ready`, and requests reach the bus in the order they were presented.
- R2: The outstanding count rises on each accepted data request and falls on each `dat_done` pulse. Fetches are not counted. When the count is at its maximum (2^CNT_W-1), data requests are held with `req_ready` low, but fetches are still accepted.
- R3: A full barrier is either `req_op`=2'b10, or `req_op`=2'b11 with `req_cls` other than 1. It is accepted at once from idle. After that, `req_ready` stays low for every request, including a second barrier, until the barrier has completed.
- R4: No SYNC command is issued while the outstanding count is non-zero.
- R5: With `cfg_bcast_en`=1, a drained full barrier issues `bus_tt`=5'h08 (SYNC) with address 0. The barrier completes only after a response with `bus_resp_valid`=1 and `bus_resp_retry`=0. Completion is shown as a one-cycle `bar_done` pulse.
- R6: A response with `bus_resp_retry`=1 causes the SYNC command to be issued again. `bar_done` stays low until a response without retry arrives.
- R7: With `cfg_bcast_en`=0, a full barrier puts no command on the bus. It pulses `bar_done` once the outstanding count reaches zero.
- R8: A barrier with `req_op`=2'b11 and `req_cls`=1 is a flowing barrier. With broadcast on, it issues `bus_tt`=5'h09 (ORDER) with address 0 in stream order and does not stall later requests. With broadcast off, it is consumed in one cycle with no bus command.
- R9: Reset leaves the unit idle with a zero count. Right after reset there is no bus command and no `bar_done`, and a full barrier with broadcast off completes without any `dat_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bcast_en | input | 1 | Broadcast barriers as SYNC/ORDER bus commands |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_op | input | 2 | 00 data, 01 fetch, 10 full barrier, 11 class-selected barrier |
| req_cls | input | CLS_W | Barrier class; 1 selects the flowing barrier |
| req_tt | input | 5 | Command code for data and fetch requests |
| req_addr | input | AW | Request address |
| bus_valid | output | 1 | Bus command valid |
| bus_ready | input | 1 | Bus accepts the command |
| bus_tt | output | 5 | Bus command code |
| bus_addr | output | AW | Bus command address |
| bus_resp_valid | input | 1 | Address response for an issued SYNC |
| bus_resp_retry | input | 1 | Response demands the SYNC be retried |
| dat_done | input | 1 | One data phase has finished |
| bar_done | output | 1 | Full barrier completed (one cycle) |

## Verification
The hardest case to reach is a full barrier that is held while data accesses are still outstanding, with a second barrier already waiting behind it, and whose SYNC is then retried. The stimulus first leaves several data accesses without completion. It then issues the first barrier and presents a class-0 barrier alongside it. The data phases are retired one at a time, after which the bench answers the first SYNC with a retry and the second with a clean response. A separate run fills the counter to its maximum to show that data requests are held while fetches still pass.

// File: rtl/barseq_pkg.sv
package barseq_pkg;

  localparam int TT_W = 5;

  typedef enum logic [1:0] {
    OP_DATA  = 2'b00,
    OP_FETCH = 2'b01,
    OP_SYNC  = 2'b10,
    OP_MBAR  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } st_e;

  localparam logic [TT_W-1:0] TT_SYNC  = 5'h08;
  localparam logic [TT_W-1:0] TT_ORDER = 5'h09;

endpackage

// File: rtl/barseq_ctr.sv
module barseq_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero,
  output logic             cnt_full
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Simultaneous increment and decrement cancel out.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (inc && !dec && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end else if (dec && !inc && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_full = (cnt_q == CNT_MAX);

endmodule

// File: rtl/barseq_fsm.sv
module barseq_fsm
  import barseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic full_take,
  input  logic bcast_en,
  input  logic cnt_zero,
  input  logic cmd_ready,
  input  logic resp_valid,
  input  logic resp_retry,
  output st_e  st
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (full_take) st_d = ST_DRAIN;
      ST_DRAIN: if (cnt_zero)  st_d = bcast_en ? ST_ISSUE : ST_DONE;
      ST_ISSUE: if (cmd_ready) st_d = ST_WAIT;
      ST_WAIT:  if (resp_valid) st_d = resp_retry ? ST_ISSUE : ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/barseq_route.sv
module barseq_route
  import barseq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CLS_W = 5
) (
  input  st_e             st,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [CLS_W-1:0] req_cls,
  input  logic [TT_W-1:0] req_tt,
  input  logic [AW-1:0]   req_addr,
  input  logic            bcast_en,
  input  logic            cnt_full,
  input  logic            bus_ready,
  output logic            req_ready,
  output logic            bus_valid,
  output logic [TT_W-1:0] bus_tt,
  output logic [AW-1:0]   bus_addr,
  output logic            data_acc,
  output logic            full_take
);

  localparam logic [CLS_W-1:0] CLS_FLOW = CLS_W'(1);

  op_e  op;
  logic is_flow, is_full;

  always_comb begin
    op      = op_e'(req_op);
    is_flow = (op == OP_MBAR) && (req_cls == CLS_FLOW);
    is_full = (op == OP_SYNC) || ((op == OP_MBAR) && !is_flow);
  end

  always_comb begin
    req_ready = 1'b0;
    bus_valid = 1'b0;
    bus_tt    = '0;
    bus_addr  = '0;
    if (st == ST_IDLE) begin
      unique case (op)
        OP_DATA: begin
          bus_valid = req_valid && !cnt_full;
          bus_tt    = req_tt;
          bus_addr  = req_addr;
          req_ready = bus_ready && !cnt_full;
        end
        OP_FETCH: begin
          bus_valid = req_valid;
          bus_tt    = req_tt;
          bus_addr  = req_addr;
          req_ready = bus_ready;
        end
        default: begin
          if (is_flow && bcast_en) begin
            bus_valid = req_valid;
            bus_tt    = TT_ORDER;
            req_ready = bus_ready;
          end else begin
            req_ready = 1'b1;
          end
        end
      endcase
    end else if (st == ST_ISSUE) begin
      bus_valid = 1'b1;
      bus_tt    = TT_SYNC;
    end
  end

  assign data_acc  = bus_valid && bus_ready && (st == ST_IDLE) && (op == OP_DATA);
  assign full_take = req_valid && is_full && (st == ST_IDLE);

endmodule

// File: rtl/barrier_seq.sv
module barrier_seq
  import barseq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CLS_W = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_bcast_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [CLS_W-1:0] req_cls,
  input  logic [4:0]       req_tt,
  input  logic [AW-1:0]    req_addr,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [4:0]       bus_tt,
  output logic [AW-1:0]    bus_addr,
  input  logic             bus_resp_valid,
  input  logic             bus_resp_retry,
  input  logic             dat_done,
  output logic             bar_done
);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero, cnt_full, data_acc, full_take;

  barseq_route #(.AW(AW), .CLS_W(CLS_W)) u_route (
    .st        (st_q),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_cls   (req_cls),
    .req_tt    (req_tt),
    .req_addr  (req_addr),
    .bcast_en  (cfg_bcast_en),
    .cnt_full  (cnt_full),
    .bus_ready (bus_ready),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_tt    (bus_tt),
    .bus_addr  (bus_addr),
    .data_acc  (data_acc),
    .full_take (full_take)
  );

  barseq_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (data_acc),
    .dec      (dat_done),
    .cnt      (cnt_q),
    .cnt_zero (cnt_zero),
    .cnt_full (cnt_full)
  );

  barseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_take  (full_take),
    .bcast_en   (cfg_bcast_en),
    .cnt_zero   (cnt_zero),
    .cmd_ready  (bus_ready),
    .resp_valid (bus_resp_valid),
    .resp_retry (bus_resp_retry),
    .st         (st_q)
  );

  assign bar_done = (st_q == ST_DONE);

endmodule

// File: rtl/barrier_seq_chk.sv
module barrier_seq_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             bus_resp_valid,
  input logic             bus_resp_retry,
  input logic             dat_done,
  input logic             bar_done,
  input logic             data_acc,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       st
);

  localparam logic [2:0]       S_IDLE  = 3'd0;
  localparam logic [2:0]       S_DRAIN = 3'd1;
  localparam logic [2:0]       S_ISSUE = 3'd2;
  localparam logic [2:0]       S_WAIT  = 3'd3;
  localparam logic [CNT_W-1:0] C_MAX   = {CNT_W{1'b1}};

  // R3: nothing is taken while a full barrier is in progress
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !req_ready);

  // R4: SYNC only goes out once drained
  a_r4_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ISSUE) |-> (cnt == '0));

  // R6: a retried SYNC is reissued and the barrier stays open
  a_r6_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && bus_resp_valid && bus_resp_retry) |=> (st == S_ISSUE && !bar_done));

  // R5, R7: completion follows either a clean response or a drain
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> (($past(st) == S_WAIT && $past(bus_resp_valid) && !$past(bus_resp_retry))
               || ($past(st) == S_DRAIN && $past(cnt) == '0)));

  // R2: no completion without an outstanding access
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dat_done |-> (cnt != '0));

  // R2: count never wraps
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |-> (cnt != C_MAX));

  // R2: an accepted data access raises the count by one
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !dat_done) |=> (cnt == $past(cnt) + 1'b1));

endmodule

bind barrier_seq barrier_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .bus_resp_valid (bus_resp_valid),
  .bus_resp_retry (bus_resp_retry),
  .dat_done       (dat_done),
  .bar_done       (bar_done),
  .data_acc       (data_acc),
  .cnt            (cnt_q),
  .st             (st_q)
);

// File: tb/barrier_seq_bench.sv
`timescale 1ns/1ps
module barrier_seq_bench;

  localparam int AW = 32;
  localparam int CLS_W = 5;
  localparam int CNT_W = 3;
  localparam logic [4:0] SYNC_C  = 5'h08;
  localparam logic [4:0] ORDER_C = 5'h09;

  logic clk, rst_n, cfg_bcast_en, req_valid, req_ready;
  logic [1:0] req_op;
  logic [CLS_W-1:0] req_cls;
  logic [4:0] req_tt, bus_tt;
  logic [AW-1:0] req_addr, bus_addr;
  logic bus_valid, bus_ready, bus_resp_valid, bus_resp_retry, dat_done, bar_done;

  barrier_seq #(.AW(AW), .CLS_W(CLS_W), .CNT_W(CNT_W)) u_barrier_seq (.*);

  typedef struct { logic [4:0] tt; logic [AW-1:0] addr; } cmd_t;
  cmd_t exp_q[$];
  int vec = 0, bad = 0, done_cnt = 0, sync_seen = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string nm(logic [4:0] t);
    if (t == SYNC_C)  return "SYNC";
    if (t == ORDER_C) return "ORDER";
    return $sformatf("tt%0h", t);
  endfunction

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic push(logic [4:0] t, logic [AW-1:0] a);
    cmd_t c;
    c.tt = t; c.addr = a;
    exp_q.push_back(c);
  endtask

  // Monitor: compares each bus handshake with the scoreboard (R1, R5, R8)
  always @(negedge clk) begin
    #1;
    if (rst_n && bus_valid && bus_ready) begin
      if (bus_tt == SYNC_C) sync_seen++;
      if (exp_q.size() == 0) begin
        chk(0, "R1", {"unexpected command ", nm(bus_tt)}, bus_tt, 0);
      end else begin
        cmd_t e;
        e = exp_q.pop_front();
        chk(bus_tt == e.tt, "R1", {"command code, expected ", nm(e.tt)}, bus_tt, e.tt);
        chk(bus_addr == e.addr, "R1", "command address", bus_addr, e.addr);
      end
    end
    if (rst_n && bar_done) done_cnt++;
  end

  task automatic issue(logic [1:0] op, logic [CLS_W-1:0] cls, logic [4:0] t,
                       logic [AW-1:0] a, output int waits);
    req_valid = 1'b1; req_op = op; req_cls = cls; req_tt = t; req_addr = a;
    waits = 0;
    forever begin
      #1;
      if (req_ready) begin
        @(negedge clk);
        break;
      end
      waits++;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic pulse_done(int n);
    repeat (n) begin @(negedge clk); dat_done = 1'b1; end
    @(negedge clk); dat_done = 1'b0;
  endtask

  task automatic resp(bit retry);
    bus_resp_valid = 1'b1; bus_resp_retry = retry;
    @(negedge clk);
    bus_resp_valid = 1'b0; bus_resp_retry = 1'b0;
  endtask

  task automatic wait_sync(int n);
    int k = 0;
    do begin @(negedge clk); #2; k++; end while (sync_seen < n && k < 200);
    chk(sync_seen >= n, "R5", "SYNC issue count", sync_seen, n);
    @(negedge clk);
  endtask

  task automatic wait_done(int n, string r);
    int k = 0;
    do begin @(negedge clk); #2; k++; end while (done_cnt < n && k < 200);
    chk(done_cnt == n, r, "barrier completion count", done_cnt, n);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int w, d0;
    rst_n = 1'b0; cfg_bcast_en = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    req_cls = '0; req_tt = '0; req_addr = '0; bus_ready = 1'b1;
    bus_resp_valid = 1'b0; bus_resp_retry = 1'b0; dat_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9: idle after reset
    chk(bus_valid == 1'b0, "R9", "bus_valid after reset", bus_valid, 0);
    chk(bar_done == 1'b0, "R9", "bar_done after reset", bar_done, 0);
    @(negedge clk);
    // R9, R7: count is zero, so a barrier with broadcast off ends without dat_done
    issue(2'b10, '0, '0, '0, w);
    wait_done(1, "R9");

    // R1: data and fetch forwarded in order
    cfg_bcast_en = 1'b1;
    push(5'h02, 32'h1000); issue(2'b00, '0, 5'h02, 32'h1000, w);
    push(5'h0A, 32'h2004); issue(2'b01, '0, 5'h0A, 32'h2004, w);
    push(5'h03, 32'h3008); issue(2'b00, '0, 5'h03, 32'h3008, w);
    // R1: bus back-pressure holds the request
    bus_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'b00; req_tt = 5'h04; req_addr = 32'h400C;
    repeat (2) begin
      #1; chk(req_ready == 1'b0, "R1", "req_ready while bus stalled", req_ready, 0);
      @(negedge clk);
    end
    bus_ready = 1'b1;
    push(5'h04, 32'h400C); issue(2'b00, '0, 5'h04, 32'h400C, w);

    // R8: flowing barrier with broadcast on, no stall
    push(ORDER_C, '0); issue(2'b11, 5'd1, 5'h1F, 32'hFFFF, w);
    chk(w == 0, "R8", "stall cycles on ORDER", w, 0);
    push(5'h05, 32'h5010); issue(2'b00, '0, 5'h05, 32'h5010, w);
    chk(w == 0, "R8", "stall cycles after ORDER", w, 0);
    // R8: broadcast off, consumed without command
    cfg_bcast_en = 1'b0;
    issue(2'b11, 5'd1, '0, '0, w);
    chk(w == 0, "R8", "stall cycles on silent flow barrier", w, 0);
    push(5'h06, 32'h6014); issue(2'b00, '0, 5'h06, 32'h6014, w);
    // outstanding data now 5

    // R3, R4, R5, R6: full barrier with drain, retry, and a second barrier waiting
    cfg_bcast_en = 1'b1;
    d0 = done_cnt;
    issue(2'b10, '0, '0, '0, w);
    chk(w == 0, "R3", "full barrier accept delay", w, 0);
    push(SYNC_C, '0); push(SYNC_C, '0); push(SYNC_C, '0);
    fork
      issue(2'b11, 5'd0, '0, '0, w);
      begin
        repeat (4) begin
          @(negedge clk); #1;
          chk(req_ready == 1'b0, "R3", "second barrier held", req_ready, 0);
          chk(bus_valid == 1'b0, "R4", "no SYNC while outstanding", bus_valid, 0);
        end
        pulse_done(5);
        wait_sync(1);
        resp(1'b1);
        wait_sync(2);
        chk(done_cnt == d0, "R6", "no completion after retry", done_cnt, d0);
        resp(1'b0);
        wait_done(d0 + 1, "R5");
      end
    join
    // R3: class 0 acts as a full barrier
    wait_sync(3);
    resp(1'b0);
    wait_done(d0 + 2, "R3");

    // R2: counter saturation holds data, not fetches
    for (int i = 0; i < 7; i++) begin
      push(5'h02, AW'(32'h8000 + 4 * i));
      issue(2'b00, '0, 5'h02, AW'(32'h8000 + 4 * i), w);
    end
    req_valid = 1'b1; req_op = 2'b00; req_tt = 5'h07; req_addr = 32'h9000;
    repeat (2) begin
      #1; chk(req_ready == 1'b0, "R2", "data held at full count", req_ready, 0);
      chk(bus_valid == 1'b0, "R2", "no data command at full count", bus_valid, 0);
      @(negedge clk);
    end
    push(5'h0B, 32'hA000); issue(2'b01, '0, 5'h0B, 32'hA000, w);
    chk(w == 0, "R2", "fetch stall at full count", w, 0);
    pulse_done(1);
    push(5'h07, 32'h9000); issue(2'b00, '0, 5'h07, 32'h9000, w);
    pulse_done(6);

    // R7: broadcast off waits for the last completion, no command
    cfg_bcast_en = 1'b0;
    d0 = done_cnt;
    issue(2'b11, 5'd2, '0, '0, w);
    repeat (3) @(negedge clk);
    #1; chk(done_cnt == d0, "R7", "completion before drain", done_cnt, d0);
    pulse_done(1);
    wait_done(d0 + 1, "R7");

    chk(exp_q.size() == 0, "R1", "commands never seen", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule